// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word addresses for a multi-register load or store. A request carries a base address, a 16-bit mask of the registers to move, an addressing mode and a write-back flag. The block then emits, one per accepted handshake, the address of each selected register together with that register's index. When the last address has gone out, it raises a one-cycle completion pulse and presents the base value the register should hold afterwards.

The addressing mode can be given directly as one of four variants: step up after each word, step up before each word, step down after each word, or step down before each word. A request can instead name a stack flavour and say whether it is a push or a pop. The flavour says whether the pointer marks the last used slot or the next free slot, and whether the stack grows toward higher or lower addresses. A small decoder turns that into the matching variant. Whatever the mode, the selected registers always sit in ascending index order at ascending addresses. So a block stored with one mode reads back with its stack partner mode.

The memory datapath and the register file sit outside this block. It only sequences addresses and register indices.

Top module: `blk_addr_seq`

## Requirements
- R1: For mode code 00 (step up after) the first address equals the base. For mode code 01 (step up before) it equals base + 4.
- R2: For mode code 11 (step down before) the first address equals base − 4·n. For mode code 10 (step down after) it equals base − 4·n + 4, where n is the number of set mask bits.
- R3: Addresses rise by 4 from one emitted word to the next. Register indices are emitted in strictly ascending order, and each set mask bit is emitted exactly once.
- R4: While `out_valid` is high and `out_ready` is low, the address and register index hold steady. Exactly one word advances per cycle with both high.
- R5: `done` rises in the cycle right after the handshake of the last word. It lasts exactly one cycle, and `out_valid` is low while it is high.
- R6: With write-back set, `final_base` at `done` is base + 4·n for step-up modes (codes 00, 01) and base − 4·n for step-down modes (codes 10, 11), in modulo 2^32 arithmetic.
- R7: With write-back clear, `final_base` at `done` equals the request's base.
- R8: A request with an all-zero mask emits no word, and `done` rises in the cycle after acceptance.
- R9: With `start_use_stack` high, `start_mode` is ignored and the mode comes from `start_stack_kind` (bit 1: 1 = grows upward, 0 = grows downward; bit 0: 1 = pointer at next free slot, 0 = pointer at last item) and `start_pop`. The full-down stack pushes with 11 and pops with 00. The full-up stack pushes with 01 and pops with 10. The empty-down stack pushes with 10 and pops with 01. The empty-up stack pushes with 00 and pops with 11.
- R10: A request is accepted only while `start_ready` is high, which holds only when no transfer is in flight. A request offered during a transfer has no effect on it.
- R11: After reset `start_ready` is high and `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | Request offered |
| start_ready | output | 1 | Block idle, request taken this cycle if offered |
| start_base | input | ADDR_W | Base address |
| start_mask | input | NREG | Register selection mask |
| start_mode | input | 2 | Direct mode: 00 up-after, 01 up-before, 10 down-after, 11 down-before |
| start_use_stack | input | 1 | Take mode from stack flavour instead of start_mode |
| start_stack_kind | input | 2 | Bit 1 grows upward, bit 0 pointer at next free slot |
| start_pop | input | 1 | 1 = pop, 0 = push (stack flavour only) |
| start_wb | input | 1 | Report the updated base |
| out_valid | output | 1 | Address and register index valid |
| out_ready | input | 1 | Consumer takes the current word |
| out_addr | output | ADDR_W | Word address |
| out_reg | output | log2(NREG) | Register index for this word |
| done | output | 1 | One-cycle completion pulse |
| final_base | output | ADDR_W | Base value after the transfer, valid with done |

## Verification
All four direct mode codes are exercised with single-bit, sparse, dense and all-ones masks. Single-bit masks separate the before/after offset from the count-based offset. Full masks show whether the count reaches 16 without truncation. Low bases that wrap through zero show modulo arithmetic in the step-down offsets. All eight stack flavour and direction pairs run with a deliberately wrong direct mode, so a decoder slip or a missing override shows up as a wrong first address. A random consumer that stalls tells apart a sequencer that holds its word from one that drifts or skips. A request offered mid-transfer with a different base and mask must leave the emitted sequence untouched.

// File: rtl/blkseq_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the block transfer address sequencer.
// Assumes mode code bit 1 selects stepping down and bit 0 selects the
// "before" variant; the stack decoder and address calculator rely on that.
package blkseq_pkg;

    typedef enum logic [1:0] {
        MODE_UP_AFTER    = 2'b00,
        MODE_UP_BEFORE   = 2'b01,
        MODE_DOWN_AFTER  = 2'b10,
        MODE_DOWN_BEFORE = 2'b11
    } xfer_mode_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_RUN  = 2'b01,
        SEQ_DONE = 2'b10
    } seq_state_t;

endpackage

// File: rtl/blkseq_stack_dec.sv
`timescale 1ns/1ps
// Module: blkseq_stack_dec
// Picks the effective transfer mode. In stack form, a push steps in the
// growth direction and a pop against it. A pointer at the last item uses
// the "before" variant for push; a pointer at the next free slot uses it
// for pop. Assumes stack_kind bit 1 = grows upward, bit 0 = empty pointer.
module blkseq_stack_dec
    import blkseq_pkg::*;
(
    input  logic       use_stack,
    input  logic [1:0] stack_kind,
    input  logic       is_pop,
    input  logic [1:0] raw_mode,
    output xfer_mode_t mode
);

    logic grows_up;
    logic ptr_empty;
    logic step_down;
    logic pre_step;

    // Derive direction and before/after from the stack flavour.
    always_comb begin
        grows_up  = stack_kind[1];
        ptr_empty = stack_kind[0];
        step_down = is_pop ? grows_up : !grows_up;
        pre_step  = is_pop ? ptr_empty : !ptr_empty;
    end

    // Select between direct mode and stack-derived mode.
    always_comb begin
        if (use_stack) begin
            mode = xfer_mode_t'({step_down, pre_step});
        end else begin
            mode = xfer_mode_t'(raw_mode);
        end
    end

endmodule

// File: rtl/blkseq_popcnt.sv
`timescale 1ns/1ps
// Module: blkseq_popcnt
// Counts the set bits of a register mask. Assumes CW can hold N.
module blkseq_popcnt #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);

    // Sum the mask bits.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/blkseq_lowbit.sv
`timescale 1ns/1ps
// Module: blkseq_lowbit
// Finds the lowest set bit of the remaining mask, returns the mask with
// that bit cleared, and flags when it was the only set bit. Output index
// is don't-care (zero) for an empty vector.
module blkseq_lowbit #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  rest,
    output logic          is_last
);

    localparam logic [N-1:0] ONE = N'(1);

    logic [N-1:0] found;

    // One-hot chain: bit i is marked when it is set and nothing below is.
    for (genvar g = 0; g < N; g++) begin : g_chain
        if (g == 0) begin : g_first
            assign found[g] = vec[g];
        end else begin : g_next
            assign found[g] = vec[g] && (vec[g-1:0] == '0);
        end
    end

    // Encode the one-hot position.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (found[i]) begin
                idx = IW'(i);
            end
        end
    end

    // Strip the lowest bit and detect the final word.
    always_comb begin
        rest    = vec & (vec - ONE);
        is_last = (rest == '0);
    end

endmodule

// File: rtl/blkseq_addr_calc.sv
`timescale 1ns/1ps
// Module: blkseq_addr_calc
// Computes the first word address and the written-back base from the base,
// mode and word count. The lowest register always gets the lowest address,
// so step-down modes start below the base by the whole block size.
// Arithmetic wraps modulo 2^AW.
module blkseq_addr_calc
    import blkseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 5,
    parameter int WB = 4
) (
    input  logic [AW-1:0] base,
    input  xfer_mode_t    mode,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] wb_base
);

    localparam logic [AW-1:0] STEP = AW'(WB);

    logic [AW-1:0] span;
    logic [AW-1:0] below;
    logic [AW-1:0] above;

    // Block size in bytes and the two possible end points.
    always_comb begin
        span  = AW'(count) * STEP;
        below = base - span;
        above = base + span;
    end

    // Starting address per mode.
    always_comb begin
        unique case (mode)
            MODE_UP_AFTER:    first_addr = base;
            MODE_UP_BEFORE:   first_addr = base + STEP;
            MODE_DOWN_AFTER:  first_addr = below + STEP;
            MODE_DOWN_BEFORE: first_addr = below;
            default:          first_addr = base;
        endcase
    end

    // Updated base: moves by the block size in the stepping direction.
    always_comb begin
        wb_base = mode[1] ? below : above;
    end

endmodule

// File: rtl/blk_addr_seq.sv
`timescale 1ns/1ps
// Module: blk_addr_seq (top)
// Sequences the word addresses of a multi-register block transfer. A
// request is taken when idle; each selected register then yields one
// address/index pair per valid-ready handshake, lowest index at lowest
// address. A one-cycle done pulse follows the last handshake and carries
// the final base. Assumes the consumer may stall indefinitely.
module blk_addr_seq
    import blkseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [NREG-1:0]   start_mask,
    input  logic [1:0]        start_mode,
    input  logic              start_use_stack,
    input  logic [1:0]        start_stack_kind,
    input  logic              start_pop,
    input  logic              start_wb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [IDX_W-1:0]  out_reg,
    output logic              done,
    output logic [ADDR_W-1:0] final_base
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    seq_state_t        state;
    logic [NREG-1:0]   rem_mask;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] fin_base;

    xfer_mode_t        eff_mode;
    logic [CNT_W-1:0]  word_cnt;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] wb_base;
    logic [IDX_W-1:0]  low_idx;
    logic [NREG-1:0]   rem_next;
    logic              last_word;
    logic              accept;
    logic              advance;

    blkseq_stack_dec u_mode (
        .use_stack  (start_use_stack),
        .stack_kind (start_stack_kind),
        .is_pop     (start_pop),
        .raw_mode   (start_mode),
        .mode       (eff_mode)
    );

    blkseq_popcnt #(.N(NREG), .CW(CNT_W)) u_cnt (
        .vec (start_mask),
        .cnt (word_cnt)
    );

    blkseq_addr_calc #(.AW(ADDR_W), .CW(CNT_W), .WB(WORD_BYTES)) u_calc (
        .base       (start_base),
        .mode       (eff_mode),
        .count      (word_cnt),
        .first_addr (first_addr),
        .wb_base    (wb_base)
    );

    blkseq_lowbit #(.N(NREG), .IW(IDX_W)) u_low (
        .vec     (rem_mask),
        .idx     (low_idx),
        .rest    (rem_next),
        .is_last (last_word)
    );

    // Handshake qualifiers for request intake and word advance.
    always_comb begin
        accept  = (state == SEQ_IDLE) && start_valid;
        advance = (state == SEQ_RUN) && out_ready;
    end

    // Sequencer state, remaining mask, running address and final base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            rem_mask <= '0;
            cur_addr <= '0;
            fin_base <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        rem_mask <= start_mask;
                        cur_addr <= first_addr;
                        fin_base <= start_wb ? wb_base : start_base;
                        state    <= (start_mask == '0) ? SEQ_DONE : SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (advance) begin
                        rem_mask <= rem_next;
                        cur_addr <= cur_addr + STEP;
                        if (last_word) begin
                            state <= SEQ_DONE;
                        end
                    end
                end
                SEQ_DONE: begin
                    state <= SEQ_IDLE;
                end
                default: begin
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Port outputs decoded from registered state.
    always_comb begin
        start_ready = (state == SEQ_IDLE);
        out_valid   = (state == SEQ_RUN);
        out_addr    = cur_addr;
        out_reg     = low_idx;
        done        = (state == SEQ_DONE);
        final_base  = fin_base;
    end

endmodule

// File: rtl/blk_addr_seq_chk.sv
`timescale 1ns/1ps
// Module: blk_addr_seq_chk
// Protocol checker bound into blk_addr_seq. Observes ports only.
module blk_addr_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic              start_ready,
    input logic [NREG-1:0]   start_mask,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [IDX_W-1:0]  out_reg,
    input logic              done
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    // R3
    ascend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=>
            (!out_valid || ((out_addr == $past(out_addr) + STEP) && (out_reg > $past(out_reg)))));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_addr) && $stable(out_reg)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R8
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready && (start_mask == '0)) |=> (done && !out_valid));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || done) |-> !start_ready);

endmodule

bind blk_addr_seq blk_addr_seq_chk #(
    .ADDR_W     (ADDR_W),
    .NREG       (NREG),
    .WORD_BYTES (WORD_BYTES)
) chk_i (.*);

// File: tb/blk_addr_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random requests against reference functions.
module blk_addr_seq_tb_top;

    localparam int AW = 32;
    localparam int NR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic          start_ready;
    logic [AW-1:0] start_base = '0;
    logic [NR-1:0] start_mask = '0;
    logic [1:0]    start_mode = '0;
    logic          start_use_stack = 1'b0;
    logic [1:0]    start_stack_kind = '0;
    logic          start_pop = 1'b0;
    logic          start_wb = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_addr;
    logic [3:0]    out_reg;
    logic          done;
    logic [AW-1:0] final_base;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    blk_addr_seq #(.ADDR_W(AW), .NREG(NR), .WORD_BYTES(4)) dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // R9 reference table written from the stack rules.
    function automatic logic [1:0] ref_mode(input bit us, input logic [1:0] kind,
                                            input bit pop, input logic [1:0] raw);
        if (!us) return raw;
        case ({kind, pop})
            3'b000: return 2'b11; // full-down push
            3'b001: return 2'b00; // full-down pop
            3'b100: return 2'b01; // full-up push
            3'b101: return 2'b10; // full-up pop
            3'b010: return 2'b10; // empty-down push
            3'b011: return 2'b01; // empty-down pop
            3'b110: return 2'b00; // empty-up push
            default: return 2'b11; // empty-up pop
        endcase
    endfunction

    function automatic logic [31:0] ref_first(input logic [31:0] b, input logic [1:0] m, input int n);
        case (m)
            2'b00: return b;
            2'b01: return b + 32'd4;
            2'b10: return b - 32'(4 * n) + 32'd4;
            default: return b - 32'(4 * n);
        endcase
    endfunction

    function automatic logic [31:0] ref_final(input logic [31:0] b, input logic [1:0] m,
                                              input int n, input bit wb);
        if (!wb) return b;
        return m[1] ? (b - 32'(4 * n)) : (b + 32'(4 * n));
    endfunction

    function automatic int low_of(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic run_xfer(input logic [31:0] base, input logic [15:0] mask,
                            input logic [1:0] raw, input bit us, input logic [1:0] kind,
                            input bit pop, input bit wb, input int rdy_pct, input bit poke);
        logic [1:0]  m;
        logic [31:0] first;
        logic [15:0] rm;
        int n, k, guard;
        bit last_hs, got_done;
        m = ref_mode(us, kind, pop, raw);
        n = $countones(mask);
        first = ref_first(base, m, n);
        rm = mask; k = 0; last_hs = 0; got_done = 0; guard = 0;
        @(negedge clk);
        check("R10", "idle ready", {31'd0, start_ready}, 32'd1);
        start_base = base; start_mask = mask; start_mode = raw; start_use_stack = us;
        start_stack_kind = kind; start_pop = pop; start_wb = wb; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        while (!got_done && guard < 400) begin
            if (poke && guard == 0 && n > 0) begin
                start_valid = 1'b1; start_base = ~base; start_mask = 16'h00FF;
                start_mode = ~raw; start_use_stack = 1'b0; start_wb = ~wb;
                check("R10", "busy ready", {31'd0, start_ready}, 32'd0);
            end else begin
                start_valid = 1'b0;
            end
            out_ready = ($urandom_range(99) < rdy_pct);
            if (last_hs || (n == 0 && guard == 0))
                check(n == 0 ? "R8" : "R5", "done timing", {31'd0, done}, 32'd1);
            if (done) begin
                got_done = 1;
                check("R5", "word count at done", k, n);
                check("R5", "valid during done", {31'd0, out_valid}, 32'd0);
                check(wb ? "R6" : "R7", "final base", final_base, ref_final(base, m, n, wb));
            end else if (out_valid) begin
                if (k >= n) begin
                    check("R3", "extra word", k, n);
                end else begin
                    check(k == 0 ? (m[1] ? "R2" : "R1") : "R3", "address", out_addr,
                          first + 32'(4 * k));
                    check("R3", "register index", {28'd0, out_reg}, low_of(rm));
                end
                if (out_ready) begin
                    k++; rm = rm & (rm - 16'd1);
                end
                last_hs = out_ready && (k == n);
            end else begin
                check("R4", "neither valid nor done", 32'd0, 32'd1);
                last_hs = 0;
            end
            guard++;
            @(negedge clk);
        end
        start_valid = 1'b0; out_ready = 1'b0;
        if (!got_done) check("R5", "transfer timeout", 32'd0, 32'd1);
        check("R5", "done single cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #1_900_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "reset valid", {31'd0, out_valid}, 32'd0);
        check("R11", "reset done", {31'd0, done}, 32'd0);
        check("R11", "reset ready", {31'd0, start_ready}, 32'd1);
        rst_n = 1'b1;

        // R1 R2: each direct mode with single, dense and full masks
        for (int md = 0; md < 4; md++) begin
            run_xfer(32'h0000_1000, 16'h8000, 2'(md), 0, 2'b00, 0, 1, 100, 0);
            run_xfer(32'h0000_2000, 16'hFFFF, 2'(md), 0, 2'b00, 0, 1, 100, 0);
            run_xfer(32'h0000_3000, 16'h4C21, 2'(md), 0, 2'b00, 0, 0, 60, 0);
        end
        // R2 R6: wrap through zero
        run_xfer(32'h0000_0004, 16'h0007, 2'b11, 0, 2'b00, 0, 1, 100, 0);
        run_xfer(32'hFFFF_FFF8, 16'h0103, 2'b00, 0, 2'b00, 0, 1, 100, 0);
        // R8: empty mask, with and without write-back
        run_xfer(32'h1234_5678, 16'h0000, 2'b11, 0, 2'b00, 0, 1, 100, 0);
        run_xfer(32'h1234_5678, 16'h0000, 2'b01, 0, 2'b00, 0, 0, 100, 0);
        // R9: every stack flavour with a misleading direct mode
        for (int kd = 0; kd < 4; kd++) begin
            for (int p = 0; p < 2; p++) begin
                run_xfer(32'h0000_8000, 16'h4C21,
                         ~ref_mode(1, 2'(kd), p[0], 2'b00), 1, 2'(kd), p[0], 1, 80, 0);
            end
        end
        // R4 R10: heavy stalls and a request offered mid-transfer
        run_xfer(32'h0000_4000, 16'hA5A5, 2'b10, 0, 2'b00, 0, 1, 25, 1);
        run_xfer(32'h0000_5000, 16'h0F0F, 2'b01, 0, 2'b00, 0, 0, 30, 1);

        // Random requests
        for (int t = 0; t < 150; t++) begin
            logic [15:0] mk;
            mk = 16'($urandom);
            if ($urandom_range(3) == 0) mk = mk & 16'($urandom);
            run_xfer($urandom, mk, 2'($urandom_range(3)), 1'($urandom_range(1)),
                     2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                     30 + $urandom_range(70), 1'($urandom_range(1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule